// File: doc/BRIEF.md
# Variable Range Register Codec

This block translates between a software-style description of a memory region (page-granular base, page count and an 8-bit memory type) and the base/mask register pair that holds one variable memory-type range. It keeps the register pairs for a small set of slots. The same engine also runs the reverse path. It decodes a stored pair back into base, size and type, and it repairs a mask whose upper bits were left clear.

Commands enter one at a time through a valid/ready handshake, and a registered response comes back one cycle after acceptance. The response is held until the consumer takes it. There are four operations. PROGRAM builds and stores the register words and reports whether they changed. READ decodes a slot. ALLOC picks a slot to use. VALIDATE checks a requested region for natural alignment and, in an optional legacy mode, for the extra restrictions of older cores. Addresses are 36 bits wide, so page numbers are 24 bits, and there are 8 slots by default.

Top module: `range_reg_codec`

## Requirements
- R1: PROGRAM (cmd_op 0) with nonzero size produces base word {base_page, 4'b0, type} and mask word {-size mod 2^24, 12'h800}, where bit 11 is the slot-enable bit. Both words are stored into the chosen slot.
- R2: PROGRAM with size 0 produces and stores zero in both the base and mask words. A later READ of that slot returns base 0, size 0 and type 0.
- R3: On PROGRAM, rsp_changed is 1 when the new base word differs from the stored one outside bits 11:8, or when the new mask word differs outside bits 10:0. It is 0 when an identical region is programmed again.
- R4: READ (cmd_op 1) of a slot whose mask bit 11 is clear returns base 0, size 0, type 0 and rsp_fixup 0.
- R5: READ of an enabled slot returns the stored base page and type. Its size is the two's complement of the mask page field. READ and PROGRAM always report error code 0.
- R6: On READ, the mask page field is first filled with ones in every position above its highest set bit. If that changes the field, rsp_fixup is 1 and the size is computed from the filled mask.
- R7: VALIDATE (cmd_op 3) shifts base and last = base+size-1 right together while the base LSB is 0 and the last LSB is 1. The result is error 1 (alignment) unless the two shifted values are then equal, in which case it is 0.
- R8: VALIDATE with cmd_legacy set returns error 2 when the base page is not a multiple of 1024 (4 MiB).
- R9: VALIDATE with cmd_legacy set returns error 2 when the type is 1 (write-combining) or 6 (write-back) and the region touches pages 0x70000 to 0x7003F, meaning base+size is at least 0x70000 and base is at most 0x7003F. Other types are not restricted by this rule.
- R10: ALLOC (cmd_op 2) returns cmd_replace as the slot when cmd_replace is below the slot count, whether or not that slot is in use.
- R11: Otherwise ALLOC returns the lowest-numbered slot whose size is zero. If there is none, it returns error 3 (no space).
- R12: cmd_ready is low while a response is held with rsp_ready low, and the held response stays stable. Each accepted command produces exactly one response, valid in the following cycle. The slot storage is updated on the accepting edge, so the next command sees it.
- R13: After reset no response is pending, cmd_ready is high and every slot is empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command present |
| cmd_ready | output | 1 | Command can be accepted |
| cmd_op | input | 2 | 0 program, 1 read, 2 alloc, 3 validate |
| cmd_slot | input | 3 | Slot for program and read |
| cmd_base | input | 24 | Base page number |
| cmd_size | input | 24 | Region size in pages |
| cmd_type | input | 8 | Memory type code |
| cmd_legacy | input | 1 | Enable legacy validation rules |
| cmd_replace | input | 4 | Preferred slot for alloc; out of range means none |
| rsp_valid | output | 1 | Response present |
| rsp_ready | input | 1 | Response consumed |
| rsp_op | output | 2 | Operation this response answers |
| rsp_err | output | 2 | 0 ok, 1 alignment, 2 legacy rule, 3 no space |
| rsp_changed | output | 1 | Program altered the stored words |
| rsp_fixup | output | 1 | Read repaired a malformed mask |
| rsp_slot | output | 3 | Slot answered or allocated |
| rsp_base | output | 24 | Base page (decoded on read, echoed otherwise) |
| rsp_size | output | 24 | Size in pages (decoded on read, echoed otherwise) |
| rsp_type | output | 8 | Type (decoded on read, echoed otherwise) |
| rsp_base_word | output | 36 | Built (program) or stored (read) base word |
| rsp_mask_word | output | 36 | Built (program) or stored (read) mask word |

## Verification
Two things can happen in the same clock edge: a stalled response drains, and the next command is accepted. That next command may then read or allocate against a slot that the previous PROGRAM just wrote. The bench holds rsp_ready low with a PROGRAM waiting on cmd_valid and checks that nothing new is accepted and the held READ response stays unchanged. It then releases rsp_ready so the drain and the acceptance share an edge, and follows at once with an ALLOC. The check passes only if the response sequence shows the PROGRAM answered next and the ALLOC skipping the slot that PROGRAM just filled.

// File: rtl/range_reg_codec.sv
module range_reg_codec #(
  parameter int NSLOTS    = 8,
  parameter int PA_W      = 36,
  parameter int LEG_ALIGN = 10,
  parameter int LEG_LO    = 'h70000,
  parameter int LEG_HI    = 'h7003F,
  parameter int TYPE_WC   = 1,
  parameter int TYPE_WB   = 6,
  localparam int PAGE_W   = PA_W - 12,
  localparam int IDX_W    = $clog2(NSLOTS)
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_valid,
  output logic              cmd_ready,
  input  logic [1:0]        cmd_op,
  input  logic [IDX_W-1:0]  cmd_slot,
  input  logic [PAGE_W-1:0] cmd_base,
  input  logic [PAGE_W-1:0] cmd_size,
  input  logic [7:0]        cmd_type,
  input  logic              cmd_legacy,
  input  logic [IDX_W:0]    cmd_replace,
  output logic              rsp_valid,
  input  logic              rsp_ready,
  output logic [1:0]        rsp_op,
  output logic [1:0]        rsp_err,
  output logic              rsp_changed,
  output logic              rsp_fixup,
  output logic [IDX_W-1:0]  rsp_slot,
  output logic [PAGE_W-1:0] rsp_base,
  output logic [PAGE_W-1:0] rsp_size,
  output logic [7:0]        rsp_type,
  output logic [PA_W-1:0]   rsp_base_word,
  output logic [PA_W-1:0]   rsp_mask_word
);

  localparam logic [1:0] OP_PROG = 2'd0;
  localparam logic [1:0] OP_READ = 2'd1;
  localparam logic [1:0] OP_ALLOC = 2'd2;
  localparam logic [1:0] OP_VAL  = 2'd3;

  localparam logic [1:0] E_OK = 2'd0;
  localparam logic [1:0] E_ALIGN = 2'd1;
  localparam logic [1:0] E_LEGACY = 2'd2;
  localparam logic [1:0] E_NOSPACE = 2'd3;

  localparam logic [PA_W-1:0] BASE_CMP = {{PAGE_W{1'b1}}, 12'h0FF};
  localparam logic [PA_W-1:0] MASK_CMP = {{PAGE_W{1'b1}}, 12'h800};
  localparam logic [PAGE_W:0] LO_P = (PAGE_W+1)'(LEG_LO);
  localparam logic [PAGE_W-1:0] HI_P = PAGE_W'(LEG_HI);

  function automatic logic [PAGE_W-1:0] fill_top(input logic [PAGE_W-1:0] m);
    logic [PAGE_W-1:0] r;
    logic hit;
    r = m;
    hit = 1'b0;
    if (m != '0) begin
      for (int i = PAGE_W - 1; i >= 0; i--) begin
        if (m[i]) hit = 1'b1;
        else if (!hit) r[i] = 1'b1;
      end
    end
    return r;
  endfunction

  logic [PA_W-1:0] base_q [NSLOTS];
  logic [PA_W-1:0] mask_q [NSLOTS];

  wire accept = cmd_valid && cmd_ready;
  assign cmd_ready = !rsp_valid || rsp_ready;

  // program path
  wire              size_nz  = |cmd_size;
  wire [PAGE_W-1:0] neg_size = -cmd_size;
  wire [PA_W-1:0]   new_bw   = size_nz ? {cmd_base, 4'b0, cmd_type} : '0;
  wire [PA_W-1:0]   new_mw   = size_nz ? {neg_size, 12'h800} : '0;
  wire [PA_W-1:0]   cur_bw   = base_q[cmd_slot];
  wire [PA_W-1:0]   cur_mw   = mask_q[cmd_slot];
  wire prog_changed = (((new_bw ^ cur_bw) & BASE_CMP) != '0) ||
                      (((new_mw ^ cur_mw) & MASK_CMP) != '0);

  // read path
  wire              rd_en    = cur_mw[11];
  wire [PAGE_W-1:0] rd_m     = cur_mw[PA_W-1:12];
  wire [PAGE_W-1:0] rd_fixed = fill_top(rd_m);
  wire              rd_fix   = rd_en && (rd_fixed != rd_m);
  wire [PAGE_W-1:0] rd_size  = rd_en ? -rd_fixed : '0;
  wire [PAGE_W-1:0] rd_base  = rd_en ? cur_bw[PA_W-1:12] : '0;
  wire [7:0]        rd_type  = rd_en ? cur_bw[7:0] : '0;

  // allocation path
  logic             free_any;
  logic [IDX_W-1:0] free_idx;
  always_comb begin
    free_any = 1'b0;
    free_idx = '0;
    for (int i = NSLOTS - 1; i >= 0; i--) begin
      if (!mask_q[i][11] || mask_q[i][PA_W-1:12] == '0) begin
        free_any = 1'b1;
        free_idx = IDX_W'(i);
      end
    end
  end
  wire rep_ok = int'(cmd_replace) < NSLOTS;

  // validation path
  wire [PAGE_W-1:0] last = cmd_base + cmd_size - 1'b1;
  logic run;
  int   sh;
  always_comb begin
    run = 1'b1;
    sh  = 0;
    for (int i = 0; i < PAGE_W; i++) begin
      if (run && !cmd_base[i] && last[i]) sh = sh + 1;
      else run = 1'b0;
    end
  end
  wire aligned   = (cmd_base >> sh) == (last >> sh);
  wire [PAGE_W:0] end_sum = {1'b0, cmd_base} + {1'b0, cmd_size};
  wire leg_mis   = |cmd_base[LEG_ALIGN-1:0];
  wire leg_hit   = !(end_sum < LO_P || cmd_base > HI_P);
  wire wr_type   = (cmd_type == 8'(TYPE_WC)) || (cmd_type == 8'(TYPE_WB));
  wire [1:0] val_err = (cmd_legacy && (leg_mis || (leg_hit && wr_type))) ? E_LEGACY :
                       aligned ? E_OK : E_ALIGN;

  // response select
  logic [1:0]        n_err;
  logic              n_chg, n_fix;
  logic [IDX_W-1:0]  n_slot;
  logic [PAGE_W-1:0] n_base, n_size;
  logic [7:0]        n_type;
  logic [PA_W-1:0]   n_bw, n_mw;
  always_comb begin
    n_err  = E_OK;
    n_chg  = 1'b0;
    n_fix  = 1'b0;
    n_slot = cmd_slot;
    n_base = cmd_base;
    n_size = cmd_size;
    n_type = cmd_type;
    n_bw   = '0;
    n_mw   = '0;
    case (cmd_op)
      OP_PROG: begin
        n_chg = prog_changed;
        n_bw  = new_bw;
        n_mw  = new_mw;
      end
      OP_READ: begin
        n_fix  = rd_fix;
        n_base = rd_base;
        n_size = rd_size;
        n_type = rd_type;
        n_bw   = cur_bw;
        n_mw   = cur_mw;
      end
      OP_ALLOC: begin
        n_slot = rep_ok ? cmd_replace[IDX_W-1:0] : free_idx;
        n_err  = (rep_ok || free_any) ? E_OK : E_NOSPACE;
      end
      default: begin
        n_slot = '0;
        n_err  = val_err;
      end
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NSLOTS; i++) begin
        base_q[i] <= '0;
        mask_q[i] <= '0;
      end
    end else if (accept && cmd_op == OP_PROG) begin
      base_q[cmd_slot] <= new_bw;
      mask_q[cmd_slot] <= new_mw;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_valid     <= 1'b0;
      rsp_op        <= OP_PROG;
      rsp_err       <= E_OK;
      rsp_changed   <= 1'b0;
      rsp_fixup     <= 1'b0;
      rsp_slot      <= '0;
      rsp_base      <= '0;
      rsp_size      <= '0;
      rsp_type      <= '0;
      rsp_base_word <= '0;
      rsp_mask_word <= '0;
    end else if (accept) begin
      rsp_valid     <= 1'b1;
      rsp_op        <= cmd_op;
      rsp_err       <= n_err;
      rsp_changed   <= n_chg;
      rsp_fixup     <= n_fix;
      rsp_slot      <= n_slot;
      rsp_base      <= n_base;
      rsp_size      <= n_size;
      rsp_type      <= n_type;
      rsp_base_word <= n_bw;
      rsp_mask_word <= n_mw;
    end else if (rsp_ready) begin
      rsp_valid <= 1'b0;
    end
  end

endmodule

// File: rtl/range_reg_codec_chk.sv
module range_reg_codec_chk #(
  parameter int PA_W   = 36,
  localparam int PAGE_W = PA_W - 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cmd_valid,
  input logic              cmd_ready,
  input logic              rsp_valid,
  input logic              rsp_ready,
  input logic [1:0]        rsp_op,
  input logic [1:0]        rsp_err,
  input logic              rsp_fixup,
  input logic [PAGE_W-1:0] rsp_size,
  input logic [PA_W-1:0]   rsp_mask_word
);

  p_stall_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |-> !cmd_ready);

  p_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && !rsp_ready |=> rsp_valid && $stable(rsp_op) && $stable(rsp_err) && $stable(rsp_size));

  p_reply_r12: assert property (@(posedge clk) disable iff (!rst_n)
    cmd_valid && cmd_ready |=> rsp_valid);

  p_prog_mask_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_op == 2'd0 && rsp_mask_word[11] |-> rsp_mask_word[PA_W-1:12] != '0);

  p_prog_zero_r2: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_op == 2'd0 && !rsp_mask_word[11] |-> rsp_mask_word == '0);

  p_fix_size_r6: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_op == 2'd1 && rsp_fixup |-> rsp_size != '0);

  p_no_err_r5: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid && rsp_op < 2'd2 |-> rsp_err == 2'd0);

endmodule

bind range_reg_codec range_reg_codec_chk #(.PA_W(PA_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
  .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_op(rsp_op), .rsp_err(rsp_err),
  .rsp_fixup(rsp_fixup), .rsp_size(rsp_size), .rsp_mask_word(rsp_mask_word)
);

// File: tb/range_reg_codec_bench.sv
module range_reg_codec_bench;

  logic clk = 0;
  always #5 clk = ~clk;

  logic        rst_n, cmd_valid, cmd_ready, cmd_legacy, rsp_valid, rsp_ready;
  logic [1:0]  cmd_op, rsp_op, rsp_err;
  logic [2:0]  cmd_slot, rsp_slot;
  logic [23:0] cmd_base, cmd_size, rsp_base, rsp_size;
  logic [7:0]  cmd_type, rsp_type;
  logic [3:0]  cmd_replace;
  logic        rsp_changed, rsp_fixup;
  logic [35:0] rsp_base_word, rsp_mask_word;

  range_reg_codec #(.NSLOTS(8), .PA_W(36)) u_range_reg_codec (
    .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_ready(cmd_ready),
    .cmd_op(cmd_op), .cmd_slot(cmd_slot), .cmd_base(cmd_base), .cmd_size(cmd_size),
    .cmd_type(cmd_type), .cmd_legacy(cmd_legacy), .cmd_replace(cmd_replace),
    .rsp_valid(rsp_valid), .rsp_ready(rsp_ready), .rsp_op(rsp_op), .rsp_err(rsp_err),
    .rsp_changed(rsp_changed), .rsp_fixup(rsp_fixup), .rsp_slot(rsp_slot),
    .rsp_base(rsp_base), .rsp_size(rsp_size), .rsp_type(rsp_type),
    .rsp_base_word(rsp_base_word), .rsp_mask_word(rsp_mask_word)
  );

  typedef struct packed {
    logic [1:0] op; logic [2:0] slot; logic [23:0] base; logic [23:0] size;
    logic [7:0] typ; logic leg; logic [3:0] rep;
    logic [1:0] e_err; logic e_chg; logic e_fix; logic [2:0] e_slot;
    logic [23:0] e_base; logic [23:0] e_size; logic [7:0] e_typ;
  } vec_t;

  function automatic vec_t mk(input logic [1:0] op, input logic [2:0] slot,
      input logic [23:0] base, input logic [23:0] size, input logic [7:0] typ,
      input logic leg, input logic [3:0] rep, input logic [1:0] e_err,
      input logic e_chg, input logic e_fix, input logic [2:0] e_slot,
      input logic [23:0] e_base, input logic [23:0] e_size, input logic [7:0] e_typ);
    vec_t v;
    v.op = op; v.slot = slot; v.base = base; v.size = size; v.typ = typ;
    v.leg = leg; v.rep = rep; v.e_err = e_err; v.e_chg = e_chg; v.e_fix = e_fix;
    v.e_slot = e_slot; v.e_base = e_base; v.e_size = e_size; v.e_typ = e_typ;
    return v;
  endfunction

  localparam int NV = 22;
  localparam vec_t VEC [NV] = '{
    mk(2, 0, 0, 0, 0, 0, 15, 0, 0, 0, 0, 0, 0, 0),                       // R13 all empty
    mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),                        // R4 disabled slot
    mk(0, 0, 'h100, 'h100, 6, 0, 0, 0, 1, 0, 0, 0, 0, 0),                // R3 new
    mk(0, 0, 'h100, 'h100, 6, 0, 0, 0, 0, 0, 0, 0, 0, 0),                // R3 identical
    mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 'h100, 'h100, 6),                // R5 decode
    mk(0, 0, 'h100, 'h100, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0),                // R3 type only
    mk(0, 1, 'h400000, 'hC00000, 0, 0, 0, 0, 1, 0, 0, 0, 0, 0),          // R3
    mk(1, 1, 0, 0, 0, 0, 0, 0, 0, 1, 0, 'h400000, 'h400000, 0),          // R6 repair
    mk(2, 0, 0, 0, 0, 0, 15, 0, 0, 0, 2, 0, 0, 0),                       // R11 first free
    mk(2, 0, 0, 0, 0, 0, 5, 0, 0, 0, 5, 0, 0, 0),                        // R10 replace
    mk(3, 0, 'h100, 'h100, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),                // R7 aligned
    mk(3, 0, 'h100, 'h200, 0, 0, 0, 1, 0, 0, 0, 0, 0, 0),                // R7 misaligned
    mk(3, 0, 'h300, 'h100, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),                // R7 aligned odd base
    mk(3, 0, 'h100, 'h100, 0, 1, 0, 2, 0, 0, 0, 0, 0, 0),                // R8 not 4 MiB
    mk(3, 0, 'h70000, 'h400, 6, 1, 0, 2, 0, 0, 0, 0, 0, 0),              // R9 write-back hit
    mk(3, 0, 'h70000, 'h400, 0, 1, 0, 0, 0, 0, 0, 0, 0, 0),              // R9 uncached ok
    mk(3, 0, 'h70400, 'h400, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0),              // R9 above window
    mk(0, 0, 'h100, 0, 1, 0, 0, 0, 1, 0, 0, 0, 0, 0),                    // R2 disable
    mk(1, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0, 0),                        // R2 read zeros
    mk(2, 0, 0, 0, 0, 0, 8, 0, 0, 0, 0, 0, 0, 0),                        // R11 freed slot
    mk(3, 0, 'h6FC00, 'h400, 1, 1, 0, 2, 0, 0, 0, 0, 0, 0),              // R9 ends on window
    mk(3, 0, 'h6F800, 'h400, 1, 1, 0, 0, 0, 0, 0, 0, 0, 0)               // R9 below window
  };

  int n_chk = 0;
  int n_err = 0;
  bit done = 0;

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [1:0] op, input logic [2:0] slot, input logic [23:0] base,
                       input logic [23:0] size, input logic [7:0] typ, input logic leg,
                       input logic [3:0] rep);
    cmd_op = op; cmd_slot = slot; cmd_base = base; cmd_size = size;
    cmd_type = typ; cmd_legacy = leg; cmd_replace = rep;
  endtask

  task automatic issue(input logic [1:0] op, input logic [2:0] slot, input logic [23:0] base,
                       input logic [23:0] size, input logic [7:0] typ, input logic leg,
                       input logic [3:0] rep);
    @(negedge clk);
    drive(op, slot, base, size, typ, leg, rep);
    cmd_valid = 1; rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog expired");
      $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
    end
  end

  initial begin
    rst_n = 0; cmd_valid = 0; rsp_ready = 1;
    drive(0, 0, 0, 0, 0, 0, 0);
    repeat (3) @(posedge clk);
    @(negedge clk); rst_n = 1;
    @(negedge clk);
    chk("R13 rsp_valid after reset", rsp_valid, 0);
    chk("R13 cmd_ready after reset", cmd_ready, 1);

    for (int k = 0; k < NV; k++) begin
      issue(VEC[k].op, VEC[k].slot, VEC[k].base, VEC[k].size, VEC[k].typ, VEC[k].leg, VEC[k].rep);
      chk("R12 response present", rsp_valid, 1);
      chk("R12 response op", rsp_op, VEC[k].op);
      chk("R5 R7 R11 error code", rsp_err, VEC[k].e_err);
      chk("R3 changed flag", rsp_changed, VEC[k].e_chg);
      chk("R6 fixup flag", rsp_fixup, VEC[k].e_fix);
      if (VEC[k].op == 2) chk("R10 R11 alloc slot", rsp_slot, VEC[k].e_slot);
      if (VEC[k].op == 1) begin
        chk("R5 read base", rsp_base, VEC[k].e_base);
        chk("R5 read size", rsp_size, VEC[k].e_size);
        chk("R5 read type", rsp_type, VEC[k].e_typ);
      end
    end

    // slot 0 empty, slot 1 holds the repaired region; stall a read of slot 1
    @(negedge clk);
    drive(1, 1, 0, 0, 0, 0, 0);
    cmd_valid = 1; rsp_ready = 0;
    @(posedge clk);
    @(negedge clk);
    chk("R12 held response valid", rsp_valid, 1);
    chk("R12 ready low while held", cmd_ready, 0);
    drive(0, 0, 'h10, 'h10, 6, 0, 0);
    repeat (3) @(negedge clk);
    chk("R12 held op stable", rsp_op, 1);
    chk("R12 held slot stable", rsp_slot, 1);
    chk("R12 held size stable", rsp_size, 'h400000);
    chk("R12 still not ready", cmd_ready, 0);
    rsp_ready = 1;
    @(posedge clk);
    @(negedge clk);
    chk("R12 program accepted on drain edge", rsp_op, 0);
    chk("R12 program response valid", rsp_valid, 1);
    drive(2, 0, 0, 0, 0, 0, 15);
    @(posedge clk);
    @(negedge clk);
    cmd_valid = 0;
    chk("R12 alloc sees fresh program", rsp_op, 2);
    chk("R11 alloc skips slot 0", rsp_slot, 2);

    for (int s = 2; s < 8; s++) issue(0, 3'(s), 24'(s), 1, 0, 0, 0);
    issue(2, 0, 0, 0, 0, 0, 15);
    chk("R11 no space error", rsp_err, 3);
    issue(2, 0, 0, 0, 0, 0, 7);
    chk("R10 replace when full err", rsp_err, 0);
    chk("R10 replace when full slot", rsp_slot, 7);

    issue(0, 3, 'h812345, 'h10, 4, 0, 0);
    chk("R1 base word", rsp_base_word, 36'h812345004);
    chk("R1 mask word", rsp_mask_word, 36'hFFFFF0800);
    chk("R3 changed on new region", rsp_changed, 1);
    issue(1, 3, 0, 0, 0, 0, 0);
    chk("R1 stored mask word", rsp_mask_word, 36'hFFFFF0800);
    chk("R5 size from mask", rsp_size, 'h10);
    issue(0, 3, 'h812345, 0, 4, 0, 0);
    chk("R2 zero base word", rsp_base_word, 0);
    chk("R2 zero mask word", rsp_mask_word, 0);
    issue(2, 0, 0, 0, 0, 0, 15);
    chk("R2 R11 disabled slot reusable", rsp_slot, 3);

    done = 1;
    $display("  Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

endmodule